// File: doc/BRIEF.md
# Single-Operand Read-Modify-Write ALU

This unit performs the one-operand 8-bit operations of a small microcontroller core on a value that the core has already fetched from a register or from memory. The core presents an operation code, the operand, the current carry flag and a valid strobe. One clock later the unit returns four things: the result, the new N (negative), Z (zero) and C (carry) values, a write enable for each of those flags, and a write-back enable for the result. The core's own write path then stores the result at the location the operand came from. Operand addressing and memory access belong to the core and are outside this unit.

The unit also performs the 8x8 unsigned multiply. A separate select input chooses it, and the second factor arrives on an index input. The 16-bit product comes back as a low byte, meant for the accumulator, and a high byte, meant for the index register. Each byte has its own write enable.

Four operation codes are unassigned. When one of them is presented, the unit raises an illegal flag and keeps every write enable low, so the core's state is left alone.

Top module: `rmw_unit`

## Requirements
- R1: All outputs are registered and due exactly one clock after the request is sampled. While reset is low, every output is 0.
- R2: The operation encoding is: 0 negate, 3 complement, 4 logical shift right, 6 rotate right through carry, 7 arithmetic shift right, 8 shift left, 9 rotate left through carry, A decrement, C increment, D test, E nibble swap, F clear. Negate returns the two's complement and writes C = 1 exactly when the operand is non-zero.
- R3: Complement (code 3) returns the bitwise inverse and leaves C unwritten.
- R4: Code 4 returns {0, x[7:1]}, code 7 returns {x[7], x[7:1]} and code 6 returns {carry_in, x[7:1]}. All three write C = x[0].
- R5: Code 8 returns {x[6:0], 0} and code 9 returns {x[6:0], carry_in}. Both write C = x[7].
- R6: Increment (C) and decrement (A) wrap modulo 256, write N and Z, and leave C unwritten.
- R7: Test (D) writes N and Z from the operand, drives the operand on the result, and keeps the write-back enable low.
- R8: Nibble swap (E) returns {x[3:0], x[7:4]} and leaves C unwritten.
- R9: Clear (F) returns 0, writes N = 0 and Z = 1, and leaves C unwritten.
- R10: Codes 1, 2, 5 and B raise the illegal flag. All write enables stay low, and the result and flags are 0.
- R11: When the multiply select is high, the operation code is ignored. The result is the low byte of operand times index, the high-byte output is the high byte, both byte enables are set, and C is written as 0. N and Z are not written.
- R12: Every non-reserved operation writes N = result[7] and Z = (result == 0). Any flag output whose enable is low reads 0, and the high-byte output is 0 for all non-multiply operations.
- R13: With valid low, every enable, the illegal flag, the valid output, the result and all flags are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| mul_i | input | 1 | Select multiply instead of op_i |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand (multiplicand for multiply) |
| idx_i | input | 8 | Second factor for multiply |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 8 | Result / low product byte |
| result_hi_o | output | 8 | High product byte |
| wb_o | output | 1 | Write-back enable for result_o |
| wb_hi_o | output | 1 | Write-back enable for result_hi_o |
| illegal_o | output | 1 | Reserved code presented |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| c_o | output | 1 | New C flag |
| n_we_o | output | 1 | N write enable |
| z_we_o | output | 1 | Z write enable |
| c_we_o | output | 1 | C write enable |

## Verification
Every result, flag, enable and the illegal flag are due one clock after the request is sampled, and none of them appears later. The bench therefore drives each request just after a falling edge, lets one rising edge register it, and compares the complete output bundle at the next falling edge. It models no extra pipeline depth.

The sweep covers all sixteen codes against all 256 operands with both carry values, and the multiply against all operands paired with sixteen index values. It also applies requests with valid low, and checks the state held during reset.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        OP_NEG  = 4'h0,
        OP_RSV1 = 4'h1,
        OP_RSV2 = 4'h2,
        OP_CPL  = 4'h3,
        OP_SRL  = 4'h4,
        OP_RSV5 = 4'h5,
        OP_RRC  = 4'h6,
        OP_SRA  = 4'h7,
        OP_SLL  = 4'h8,
        OP_RLC  = 4'h9,
        OP_DEC  = 4'hA,
        OP_RSVB = 4'hB,
        OP_INC  = 4'hC,
        OP_TNZ  = 4'hD,
        OP_SWAP = 4'hE,
        OP_CLR  = 4'hF
    } rmw_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic n_we;
        logic z_we;
        logic c_we;
    } rmw_flags_t;

    function automatic logic op_is_reserved(rmw_op_e op);
        return (op == OP_RSV1) || (op == OP_RSV2) ||
               (op == OP_RSV5) || (op == OP_RSVB);
    endfunction

    function automatic logic op_writes_carry(rmw_op_e op);
        return (op == OP_NEG) || (op == OP_SRL) || (op == OP_RRC) ||
               (op == OP_SRA) || (op == OP_SLL) || (op == OP_RLC);
    endfunction

endpackage

// File: rtl/rmw_shifter.sv
module rmw_shifter
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  rmw_op_e        op,
    input  logic [W-1:0]   x,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout,
    output logic           hit
);
    localparam int H = W / 2;

    always_comb begin
        y    = x;
        cout = cin;
        hit  = 1'b1;
        unique case (op)
            OP_SRL: begin
                y    = {1'b0, x[W-1:1]};
                cout = x[0];
            end
            OP_SRA: begin
                y    = {x[W-1], x[W-1:1]};
                cout = x[0];
            end
            OP_RRC: begin
                y    = {cin, x[W-1:1]};
                cout = x[0];
            end
            OP_SLL: begin
                y    = {x[W-2:0], 1'b0};
                cout = x[W-1];
            end
            OP_RLC: begin
                y    = {x[W-2:0], cin};
                cout = x[W-1];
            end
            OP_SWAP: begin
                y    = {x[H-1:0], x[W-1:H]};
            end
            default: begin
                hit  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmw_arith.sv
module rmw_arith
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  rmw_op_e        op,
    input  logic [W-1:0]   x,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    always_comb begin
        y    = x;
        cout = cin;
        unique case (op)
            OP_NEG: begin
                y    = ZERO - x;
                cout = |x;
            end
            OP_CPL:  y = ~x;
            OP_DEC:  y = x - ONE;
            OP_INC:  y = x + ONE;
            OP_TNZ:  y = x;
            OP_CLR:  y = ZERO;
            default: y = x;
        endcase
    end

endmodule

// File: rtl/rmw_mult.sv
module rmw_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-1:0]   p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] pp [W];

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : {PW{1'b0}};
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            p = p + pp[i];
        end
    end

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic           mul_i,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opnd_i,
    input  logic [W-1:0]   idx_i,
    input  logic           carry_i,
    output logic           valid_o,
    output logic [W-1:0]   result_o,
    output logic [W-1:0]   result_hi_o,
    output logic           wb_o,
    output logic           wb_hi_o,
    output logic           illegal_o,
    output logic           n_o,
    output logic           z_o,
    output logic           c_o,
    output logic           n_we_o,
    output logic           z_we_o,
    output logic           c_we_o
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] hi;
        logic         wb;
        logic         wb_hi;
        logic         ill;
        logic         vld;
        rmw_flags_t   fl;
    } stage_t;

    rmw_op_e       op;
    logic [W-1:0]  sh_y, ar_y, sel_y;
    logic          sh_c, ar_c, sel_c, sh_hit;
    logic [PW-1:0] prod;
    stage_t        stage_d, stage_q;

    assign op = rmw_op_e'(op_i);

    rmw_shifter #(.W(W)) u_shift (
        .op   (op),
        .x    (opnd_i),
        .cin  (carry_i),
        .y    (sh_y),
        .cout (sh_c),
        .hit  (sh_hit)
    );

    rmw_arith #(.W(W)) u_arith (
        .op   (op),
        .x    (opnd_i),
        .cin  (carry_i),
        .y    (ar_y),
        .cout (ar_c)
    );

    rmw_mult #(.W(W)) u_mult (
        .a (opnd_i),
        .b (idx_i),
        .p (prod)
    );

    assign sel_y = sh_hit ? sh_y : ar_y;
    assign sel_c = sh_hit ? sh_c : ar_c;

    always_comb begin
        stage_d = '0;
        if (valid_i) begin
            stage_d.vld = 1'b1;
            if (mul_i) begin
                stage_d.res     = prod[W-1:0];
                stage_d.hi      = prod[PW-1:W];
                stage_d.wb      = 1'b1;
                stage_d.wb_hi   = 1'b1;
                stage_d.fl.c_we = 1'b1;
                stage_d.fl.c    = 1'b0;
            end else if (op_is_reserved(op)) begin
                stage_d.ill     = 1'b1;
            end else begin
                stage_d.res     = sel_y;
                stage_d.wb      = (op != OP_TNZ);
                stage_d.fl.n_we = 1'b1;
                stage_d.fl.z_we = 1'b1;
                stage_d.fl.n    = sel_y[W-1];
                stage_d.fl.z    = (sel_y == '0);
                stage_d.fl.c_we = op_writes_carry(op);
                stage_d.fl.c    = op_writes_carry(op) & sel_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign valid_o     = stage_q.vld;
    assign result_o    = stage_q.res;
    assign result_hi_o = stage_q.hi;
    assign wb_o        = stage_q.wb;
    assign wb_hi_o     = stage_q.wb_hi;
    assign illegal_o   = stage_q.ill;
    assign n_o         = stage_q.fl.n;
    assign z_o         = stage_q.fl.z;
    assign c_o         = stage_q.fl.c;
    assign n_we_o      = stage_q.fl.n_we;
    assign z_we_o      = stage_q.fl.z_we;
    assign c_we_o      = stage_q.fl.c_we;

endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           valid_i,
    input logic           mul_i,
    input logic [3:0]     op_i,
    input logic [W-1:0]   opnd_i,
    input logic [W-1:0]   idx_i,
    input logic           carry_i,
    input logic           valid_o,
    input logic [W-1:0]   result_o,
    input logic [W-1:0]   result_hi_o,
    input logic           wb_o,
    input logic           wb_hi_o,
    input logic           illegal_o,
    input logic           n_o,
    input logic           z_o,
    input logic           c_o,
    input logic           n_we_o,
    input logic           z_we_o,
    input logic           c_we_o
);
    logic rsv;
    assign rsv = (op_i == 4'h1) || (op_i == 4'h2) || (op_i == 4'h5) || (op_i == 4'hB);

    // R13: an idle cycle produces no writes
    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && !wb_o && !wb_hi_o && !illegal_o && !n_we_o && !z_we_o && !c_we_o));

    // R10: reserved codes flag illegal and suppress every write
    p_reserved_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mul_i && rsv) |=> (illegal_o && !wb_o && !wb_hi_o && !n_we_o && !z_we_o && !c_we_o));

    // R6: increment and decrement never write carry
    p_incdec_keep_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mul_i && (op_i == 4'hA || op_i == 4'hC)) |=> (!c_we_o && n_we_o && z_we_o && wb_o));

    // R7: test writes flags from the operand but no result
    p_test_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mul_i && op_i == 4'hD) |=> (!wb_o && z_we_o && (z_o == ($past(opnd_i) == '0))));

    // R9: clear yields zero with fixed flags
    p_clear_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mul_i && op_i == 4'hF) |=> (result_o == '0 && z_o && !n_o && wb_o));

    // R2: negate carry reflects a non-zero operand
    p_neg_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mul_i && op_i == 4'h0) |=> (c_we_o && (c_o == ($past(opnd_i) != '0))));

    // R11: multiply product and carry clear
    p_mul_product_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mul_i) |=> ({result_hi_o, result_o} == ($past(opnd_i) * $past(idx_i))
                                && wb_hi_o && c_we_o && !c_o && !n_we_o && !illegal_o));

    // R12: a flag without its enable reads zero
    p_masked_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((n_we_o || !n_o) && (z_we_o || !z_o) && (c_we_o || !c_o)));

endmodule

bind rmw_unit rmw_unit_chk #(.W(W)) u_rmw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .mul_i       (mul_i),
    .op_i        (op_i),
    .opnd_i      (opnd_i),
    .idx_i       (idx_i),
    .carry_i     (carry_i),
    .valid_o     (valid_o),
    .result_o    (result_o),
    .result_hi_o (result_hi_o),
    .wb_o        (wb_o),
    .wb_hi_o     (wb_hi_o),
    .illegal_o   (illegal_o),
    .n_o         (n_o),
    .z_o         (z_o),
    .c_o         (c_o),
    .n_we_o      (n_we_o),
    .z_we_o      (z_we_o),
    .c_we_o      (c_we_o)
);

// File: tb/rmw_unit_test.sv
module rmw_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid_i, mul_i, carry_i;
    logic [3:0] op_i;
    logic [7:0] opnd_i, idx_i;
    logic       valid_o, wb_o, wb_hi_o, illegal_o;
    logic [7:0] result_o, result_hi_o;
    logic       n_o, z_o, c_o, n_we_o, z_we_o, c_we_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rmw_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mul_i(mul_i), .op_i(op_i),
        .opnd_i(opnd_i), .idx_i(idx_i), .carry_i(carry_i), .valid_o(valid_o),
        .result_o(result_o), .result_hi_o(result_hi_o), .wb_o(wb_o), .wb_hi_o(wb_hi_o),
        .illegal_o(illegal_o), .n_o(n_o), .z_o(z_o), .c_o(c_o),
        .n_we_o(n_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o)
    );

    // bundle: res, hi, wb, wb_hi, ill, vld, n, z, c, n_we, z_we, c_we
    function automatic logic [25:0] actual();
        return {result_o, result_hi_o, wb_o, wb_hi_o, illegal_o, valid_o,
                n_o, z_o, c_o, n_we_o, z_we_o, c_we_o};
    endfunction

    function automatic logic [25:0] model(logic v, logic m, logic [3:0] op,
                                          logic [7:0] x, logic [7:0] ix, logic ci);
        logic [7:0]  y;
        logic [15:0] p;
        logic        c, cw, wb;
        if (!v) return '0;
        if (m) begin
            p = 16'(x) * 16'(ix);
            return {p[7:0], p[15:8], 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        end
        if (op == 4'h1 || op == 4'h2 || op == 4'h5 || op == 4'hB)
            return {16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 6'b0};
        c = 1'b0; cw = 1'b0; wb = 1'b1; y = x;
        case (op)
            4'h0: begin y = 8'(256 - int'(x)); cw = 1'b1; c = (x != 0); end
            4'h3: y = 8'hFF ^ x;
            4'h4: begin y = x / 2; cw = 1'b1; c = x[0]; end
            4'h6: begin y = (x / 2) + (ci ? 8'h80 : 8'h00); cw = 1'b1; c = x[0]; end
            4'h7: begin y = (x / 2) + (x[7] ? 8'h80 : 8'h00); cw = 1'b1; c = x[0]; end
            4'h8: begin y = 8'((int'(x) * 2) % 256); cw = 1'b1; c = x[7]; end
            4'h9: begin y = 8'((int'(x) * 2 + int'(ci)) % 256); cw = 1'b1; c = x[7]; end
            4'hA: y = 8'((int'(x) + 255) % 256);
            4'hC: y = 8'((int'(x) + 1) % 256);
            4'hD: wb = 1'b0;
            4'hE: y = 8'((int'(x) % 16) * 16 + int'(x) / 16);
            4'hF: y = 8'h00;
            default: y = x;
        endcase
        return {y, 8'h00, wb, 1'b0, 1'b0, 1'b1, y[7], (y == 8'h00), c, 1'b1, 1'b1, cw};
    endfunction

    function automatic string tag_of(logic v, logic m, logic [3:0] op);
        if (!v) return "R13";
        if (m) return "R11";
        case (op)
            4'h0: return "R2";
            4'h3: return "R3";
            4'h4, 4'h6, 4'h7: return "R4";
            4'h8, 4'h9: return "R5";
            4'hA, 4'hC: return "R6";
            4'hD: return "R7";
            4'hE: return "R8";
            4'hF: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(string tag, logic [25:0] exp);
        logic [25:0] got;
        got = actual();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%h x=%h ix=%h cin=%b actual=%h expected=%h",
                     tag, op_i, opnd_i, idx_i, carry_i, got, exp);
        end
    endtask

    // caller stands just after a falling edge; result due after one rising edge (R1)
    task automatic run(logic v, logic m, logic [3:0] op, logic [7:0] x, logic [7:0] ix, logic ci);
        valid_i = v; mul_i = m; op_i = op; opnd_i = x; idx_i = ix; carry_i = ci;
        @(negedge clk);
        compare(tag_of(v, m, op), model(v, m, op, x, ix, ci));
        // R12 is covered by every non-reserved entry of the bundle
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid_i = 1'b1; mul_i = 1'b0; op_i = 4'h0;
        opnd_i = 8'h55; idx_i = 8'h0; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", '0);       // reset state
        rst_n = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);

        for (int op = 0; op < 16; op++) begin
            for (int x = 0; x < 256; x++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    run(1'b1, 1'b0, 4'(op), 8'(x), 8'(x * 7), 1'(ci));
                end
            end
        end

        for (int x = 0; x < 256; x++) begin
            for (int k = 0; k < 16; k++) begin
                run(1'b1, 1'b1, 4'(k), 8'(x), 8'(k * 17 + (k == 15 ? 0 : 0)), 1'(k));
            end
        end
        run(1'b1, 1'b1, 4'h2, 8'hFF, 8'hFF, 1'b1);   // R11 largest product

        run(1'b0, 1'b0, 4'h0, 8'h05, 8'h00, 1'b1);   // R13 negate ignored
        run(1'b0, 1'b1, 4'hF, 8'hFF, 8'hFF, 1'b0);   // R13 multiply ignored
        run(1'b0, 1'b0, 4'h1, 8'h00, 8'h00, 1'b0);   // R13 reserved ignored
        run(1'b1, 1'b0, 4'hF, 8'hA5, 8'h00, 1'b1);   // R9 back-to-back after idle

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule